// File: doc/BRIEF.md
# Character Memory Slot Mapper with Outer Block Select

This block sits between the picture unit's pattern-table address bus and a large character memory. It splits the 8 KB pattern space into eight 1 KB windows. Each window is steered to a physical 1 KB bank. The bank number has two parts. The upper part is an outer block assembled from a CPU-side extended register and two picture-side configuration registers. The lower part is a per-window bank value, trimmed by a size mask. The block also reports the nametable mirroring arrangement.

Software programs the mapper through writes on one shared write port. A sixteen-entry configuration window covers 0x2010-0x201F. One outer-select register sits at 0x4100. A command/data register pair is decoded anywhere in 0x8000-0x9FFF. A mirroring register is decoded in 0xA000-0xBFFF. The lookup from picture address to physical character address is purely combinational from the registered configuration.

Top module: `outer_chr_mapper`

## Requirements
- R1: After reset every configuration register is zero. The output is then `chr_addr` = 0x000000 for picture address 0x0000 and 0x000400 for 0x0400, and `mirror_horiz` = 0.
- R2: A write with `wr_addr[15:4]` = 0x201 stores `wr_data` into configuration entry `wr_addr[3:0]`.
- R3: The size mask is 0xFF shifted right by a shift taken from entry 10 bits [2:0]. The shift values for selectors 0..7 are 0,1,2,0,3,4,5,0.
- R4: The outer block is a 15-bit value laid out from most to least significant bit as follows. Bits 14:11 are the outer-select register bits [3:0]. Bits 10:8 are entry 8 bits [6:4]. Bits 7:0 are entry 10 ANDed with the inverted mask.
- R5: Each window's bank is the block ORed with (source value AND mask). Windows 0 and 1 take entry 6 with bit 0 forced to 0 and to 1 respectively. Windows 2 and 3 do the same with entry 7. Windows 4..7 take entries 2..5.
- R6: When command bit 7 is set, picture address bit 12 is inverted before window selection. This exchanges the lower and upper 4 KB halves.
- R7: A write at an address with bits {15,14,13,0} = 1,0,0,1 is a data-port write. It stores into entry 6, 7, 2, 3, 4 or 5 when command bits [2:0] are 0..5. When those bits are 6 or 7 the write changes no character mapping.
- R8: A write at an address with bits {15,14,13,0} = 1,0,0,0 updates command bits 7,6,2,1,0 from the data. The write leaves command bits 5:3 unchanged.
- R9: A write at an address with bits {15,14,13,0} = 1,0,1,0 stores the mirroring register. `mirror_horiz` is its bit 0 (1 = horizontal, 0 = vertical).
- R10: Writes to any other address, and cycles with `wr_en` low, leave the mapping and mirroring unchanged.
- R11: The output is `{bank, a[9:0]}`, where `a` is the picture address after the half swap. A write changes the output only after the rising clock edge that takes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| ppu_addr | input | 13 | Picture-unit pattern address |
| chr_addr | output | 25 | Physical character memory address |
| mirror_horiz | output | 1 | 1 = horizontal mirroring, 0 = vertical |

## Verification
The hardest situation to reach is a non-trivial size mask combined with a populated outer block and the half swap all at once. In that case bits from entry 10 leak into the bank only above the mask while the window value fills the rest. Random writes alone seldom line up entry 10, entry 8, the outer register and command bit 7 together. Directed sequences therefore set each mask selector, including the irregular ones mapping back to a full mask, under a non-zero outer block before random traffic reuses that state. Data-port writes with command indices 6 and 7 are issued deliberately and followed by lookups across all eight windows.

// File: rtl/ocm_pkg.sv
package ocm_pkg;
    localparam int REG_W     = 8;
    localparam int NUM_WIN   = 16;
    localparam int IDX_W     = $clog2(NUM_WIN);
    localparam int NUM_SLOTS = 8;
    localparam int SEL_W     = $clog2(NUM_SLOTS);
    localparam int SLOT_W    = 10;
    localparam int PPU_AW    = SEL_W + SLOT_W;
    localparam int OUTER_W   = 4;
    localparam int MID_W     = 3;
    localparam int BANK_W    = OUTER_W + MID_W + REG_W;
    localparam int CHR_AW    = BANK_W + SLOT_W;
    localparam int CPU_AW    = 16;

    localparam int E_MASK  = 10;
    localparam int E_MID   = 8;
    localparam int E_PAIR0 = 6;
    localparam int E_PAIR1 = 7;
    localparam int E_SING0 = 2;

    typedef logic [REG_W-1:0] reg_t;
    typedef logic [BANK_W-1:0] bank_t;

    typedef struct packed {
        reg_t [NUM_WIN-1:0] win;
        reg_t               outer;
        reg_t               cmd;
        reg_t               mirr;
    } cfg_t;

    function automatic logic [2:0] mask_shift(input logic [2:0] sel);
        logic [2:0] s;
        case (sel)
            3'd1:    s = 3'd1;
            3'd2:    s = 3'd2;
            3'd4:    s = 3'd3;
            3'd5:    s = 3'd4;
            3'd6:    s = 3'd5;
            default: s = 3'd0;
        endcase
        return s;
    endfunction
endpackage

// File: rtl/chr_cfg_regs.sv
module chr_cfg_regs
    import ocm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CPU_AW-1:0] wr_addr,
    input  reg_t              wr_data,
    output cfg_t              cfg
);
    localparam logic [CPU_AW-5:0] WIN_BASE  = 12'h201;
    localparam logic [CPU_AW-1:0] OUTER_ADR = 16'h4100;
    localparam reg_t              CMD_KEEP  = 8'h38;

    cfg_t cfg_d, cfg_q;

    logic hi_sel;
    logic [2:0] hi_kind;
    always_comb begin
        hi_sel  = wr_addr[15];
        hi_kind = {wr_addr[14:13], wr_addr[0]};
    end

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (wr_addr[CPU_AW-1:4] == WIN_BASE) begin
                cfg_d.win[wr_addr[IDX_W-1:0]] = wr_data;
            end else if (wr_addr == OUTER_ADR) begin
                cfg_d.outer = wr_data;
            end else if (hi_sel) begin
                case (hi_kind)
                    3'b000: cfg_d.cmd = (cfg_q.cmd & CMD_KEEP) | (wr_data & ~CMD_KEEP);
                    3'b001: begin
                        case (cfg_q.cmd[2:0])
                            3'd0: cfg_d.win[E_PAIR0] = wr_data;
                            3'd1: cfg_d.win[E_PAIR1] = wr_data;
                            3'd2, 3'd3, 3'd4, 3'd5:
                                cfg_d.win[IDX_W'(cfg_q.cmd[2:0])] = wr_data;
                            default: ;
                        endcase
                    end
                    3'b010: cfg_d.mirr = wr_data;
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    AST_WIN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[CPU_AW-1:4] == WIN_BASE)
        |=> cfg_q.win[$past(wr_addr[IDX_W-1:0])] == $past(wr_data)); // R2
    AST_CMD_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[15:13] == 3'b100 && !wr_addr[0])
        |=> cfg_q.cmd[5:3] == $past(cfg_q.cmd[5:3])); // R8
    AST_MIRR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr[15:13] == 3'b101 && !wr_addr[0])
        |=> cfg_q.mirr == $past(wr_data)); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_q)); // R10
endmodule

// File: rtl/chr_bank_calc.sv
module chr_bank_calc
    import ocm_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst_n,
    input  cfg_t                       cfg,
    output reg_t                       mask,
    output bank_t [NUM_SLOTS-1:0]      banks
);
    bank_t blk;

    always_comb begin
        mask = reg_t'(8'hFF >> mask_shift(cfg.win[E_MASK][2:0]));
        blk  = {cfg.outer[OUTER_W-1:0], cfg.win[E_MID][6:4],
                cfg.win[E_MASK] & ~mask};
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        reg_t src;
        if (s < 4) begin : g_pair
            always_comb src = {cfg.win[E_PAIR0 + s/2][REG_W-1:1], 1'(s % 2)};
        end else begin : g_single
            always_comb src = cfg.win[E_SING0 + s - 4];
        end
        always_comb banks[s] = blk | bank_t'(src & mask);
    end

    logic unused_cfg_bits;
    assign unused_cfg_bits = ^{cfg.win[0], cfg.win[1], cfg.win[9],
                               cfg.win[15:11], cfg.win[E_MID][7],
                               cfg.win[E_MID][3:0], cfg.outer[7:4],
                               cfg.win[E_PAIR0][0], cfg.win[E_PAIR1][0],
                               cfg.cmd, cfg.mirr};

    AST_PAIR_PARITY: assert property (@(posedge clk) disable iff (!rst_n)
        !banks[0][0] && banks[1][0] && !banks[2][0] && banks[3][0]); // R5
endmodule

// File: rtl/chr_addr_xlat.sv
module chr_addr_xlat
    import ocm_pkg::*;
(
    input  logic [PPU_AW-1:0]     ppu_addr,
    input  logic                  half_swap,
    input  bank_t [NUM_SLOTS-1:0] banks,
    output logic [CHR_AW-1:0]     chr_addr
);
    logic [PPU_AW-1:0] eff;
    always_comb begin
        eff      = ppu_addr ^ {half_swap, {(PPU_AW-1){1'b0}}};
        chr_addr = {banks[eff[PPU_AW-1:SLOT_W]], eff[SLOT_W-1:0]};
    end
endmodule

// File: rtl/outer_chr_mapper.sv
module outer_chr_mapper
    import ocm_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [15:0]        wr_addr,
    input  logic [7:0]         wr_data,
    input  logic [12:0]        ppu_addr,
    output logic [24:0]        chr_addr,
    output logic               mirror_horiz
);
    cfg_t                  cfg;
    reg_t                  mask;
    bank_t [NUM_SLOTS-1:0] banks;

    chr_cfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .cfg(cfg)
    );

    chr_bank_calc u_calc (
        .clk(clk), .rst_n(rst_n), .cfg(cfg), .mask(mask), .banks(banks)
    );

    chr_addr_xlat u_xlat (
        .ppu_addr(ppu_addr), .half_swap(cfg.cmd[7]),
        .banks(banks), .chr_addr(chr_addr)
    );

    assign mirror_horiz = cfg.mirr[0];

    AST_MASK_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot({1'b0, mask} + 9'd1) && mask[1:0] == 2'b11); // R3
    AST_OFFSET_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        chr_addr[SLOT_W-1:0] == ppu_addr[SLOT_W-1:0]); // R11
endmodule

// File: tb/sim_outer_chr_mapper.sv
module sim_outer_chr_mapper;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [15:0] wr_addr = 0;
    logic [7:0]  wr_data = 0;
    logic [12:0] ppu_addr = 0;
    logic [24:0] chr_addr;
    logic        mirror_horiz;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    logic [7:0] m_win [16];
    logic [7:0] m_outer, m_cmd, m_mirr;

    always #2 clk = ~clk;

    outer_chr_mapper u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ppu_addr(ppu_addr), .chr_addr(chr_addr),
        .mirror_horiz(mirror_horiz)
    );

    function automatic int shift_of(input logic [2:0] s);
        int t [8] = '{0, 1, 2, 0, 3, 4, 5, 0};
        return t[s];
    endfunction

    function automatic logic [24:0] model(input logic [12:0] pa);
        logic [12:0] a;
        logic [7:0] mk, v;
        logic [14:0] blk, bank;
        int w;
        a = m_cmd[7] ? (pa ^ 13'h1000) : pa;
        w = int'(a[12:10]);
        mk = 8'hFF >> shift_of(m_win[10][2:0]);
        blk = (15'(m_outer[3:0]) << 11) + (15'(m_win[8][6:4]) << 8)
              + 15'(m_win[10] & ~mk);
        case (w)
            0: v = {m_win[6][7:1], 1'b0};
            1: v = {m_win[6][7:1], 1'b1};
            2: v = {m_win[7][7:1], 1'b0};
            3: v = {m_win[7][7:1], 1'b1};
            default: v = m_win[w - 2];
        endcase
        bank = blk | 15'(v & mk);
        return {bank, a[9:0]};
    endfunction

    task automatic model_write(input logic [15:0] ad, input logic [7:0] d);
        if (ad[15:4] == 12'h201) m_win[ad[3:0]] = d;
        else if (ad == 16'h4100) m_outer = d;
        else if (ad[15:13] == 3'b100 && !ad[0]) m_cmd = (m_cmd & 8'h38) | (d & 8'hC7);
        else if (ad[15:13] == 3'b100 && ad[0]) begin
            case (m_cmd[2:0])
                3'd0: m_win[6] = d;
                3'd1: m_win[7] = d;
                3'd6, 3'd7: ;
                default: m_win[m_cmd[2:0]] = d;
            endcase
        end else if (ad[15:13] == 3'b101 && !ad[0]) m_mirr = d;
    endtask

    task automatic wr(input logic [15:0] ad, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = ad; wr_data = d;
        @(negedge clk);
        wr_en = 0;
        model_write(ad, d);
    endtask

    task automatic chk(input logic [12:0] pa, input string tag);
        logic [24:0] e;
        ppu_addr = pa;
        #1;
        e = model(pa);
        tests++;
        if (chr_addr !== e) begin
            fails++;
            $display("FAIL %s pa=%h chr_addr=%h expected %h", tag, pa, chr_addr, e);
        end
    endtask

    task automatic chk_mirr(input string tag);
        #1;
        tests++;
        if (mirror_horiz !== m_mirr[0]) begin
            fails++;
            $display("FAIL %s mirror_horiz=%b expected %b", tag, mirror_horiz, m_mirr[0]);
        end
    endtask

    task automatic chk_all(input string tag);
        for (int s = 0; s < 8; s++) chk(13'(s * 1024 + 37 * s), tag);
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] ad;
        logic [31:0] r;
        void'($urandom(32'd7331));
        foreach (m_win[i]) m_win[i] = 0;
        m_outer = 0; m_cmd = 0; m_mirr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state, hard-coded expectations
        ppu_addr = 13'h0000; #1; tests++;
        if (chr_addr !== 25'h0) begin fails++; $display("FAIL R1 chr_addr=%h expected 000000", chr_addr); end
        ppu_addr = 13'h0400; #1; tests++;
        if (chr_addr !== 25'h400) begin fails++; $display("FAIL R1 chr_addr=%h expected 000400", chr_addr); end
        chk_mirr("R1");

        // R2 / R5 window write and pair windows
        wr(16'h2016, 8'h35);
        chk(13'h0000, "R5"); chk(13'h0400, "R5");
        ppu_addr = 13'h0000; #1; tests++;
        if (chr_addr !== {15'h34, 10'h0}) begin fails++; $display("FAIL R2 chr_addr=%h expected %h", chr_addr, {15'h34, 10'h0}); end
        wr(16'h2012, 8'hC3); wr(16'h2015, 8'h7E); wr(16'h2017, 8'h11);
        chk_all("R5");

        // R3 all mask selectors with entry 10 upper bits set
        wr(16'h2014, 8'h5A);
        for (int s = 0; s < 8; s++) begin
            wr(16'h201A, 8'hA8 | 8'(s));
            chk_all("R3");
        end

        // R4 outer block composition
        wr(16'h4100, 8'hA7); wr(16'h2018, 8'hD0); wr(16'h201A, 8'h65);
        chk_all("R4");

        // R6 half swap
        wr(16'h8000, 8'h80);
        chk_all("R6");
        wr(16'h9FFE, 8'h00);
        chk_all("R6");

        // R7 data port indices 0..7 and R8 command keep bits
        for (int c = 0; c < 8; c++) begin
            wr(16'h8000, 8'h38 | 8'(c));
            wr(16'h8001, 8'(8'h90 + c * 3));
            chk_all("R7");
        end

        // R9 mirroring
        wr(16'hA000, 8'h01); chk_mirr("R9");
        wr(16'hA001, 8'h00); chk_mirr("R10");
        wr(16'hBFFE, 8'hFE); chk_mirr("R9");

        // R10 ignored addresses
        wr(16'h4101, 8'hFF); wr(16'hC000, 8'hFF); wr(16'hE001, 8'hFF);
        wr(16'h2000, 8'hFF); wr(16'h4110, 8'hFF);
        chk_all("R10"); chk_mirr("R10");

        // R11 write not visible before its clock edge
        @(negedge clk);
        wr_en = 1; wr_addr = 16'h2012; wr_data = ~m_win[2];
        chk(13'h1000, "R11");
        @(negedge clk);
        wr_en = 0;
        model_write(16'h2012, wr_data);
        chk(13'h1000, "R11");

        // random traffic
        for (int i = 0; i < 600; i++) begin
            r = $urandom();
            case (r[3:0])
                4'd0, 4'd1, 4'd2: ad = {12'h201, 4'(r[7:4])};
                4'd3: ad = 16'h4100;
                4'd4, 4'd5: ad = {3'b100, 12'(r[19:8]), 1'b0};
                4'd6, 4'd7, 4'd8: ad = {3'b100, 12'(r[19:8]), 1'b1};
                4'd9: ad = {3'b101, 12'(r[19:8]), 1'b0};
                default: ad = 16'($urandom());
            endcase
            wr(ad, 8'($urandom()));
            chk(13'($urandom()), "R5");
            chk(13'($urandom()), "R4");
            chk_mirr("R9");
        end

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule